// File: doc/BRIEF.md
# Parity-Checked Line Capture Engine

This block collects one text line from a stream of 8-bit characters handed over by a terminal receiver. Each character carries an even-parity bit in its top bit. The engine checks that bit, drops it, and writes the remaining 7-bit code into a small line buffer. A carriage return ends the line: the engine stores it, writes a line feed after it, and leaves the total byte count in a register. A character with bad parity aborts the line. A line that grows past its limit without a carriage return also aborts, and each abort raises its own sticky flag.

Software starts a capture with a one-cycle start pulse. Characters arrive over a valid/ready handshake, which is open only while a capture runs. A byte-wide register port gives access to the last stored character, a transmit holding register, a status word and the byte count. The buffer contents can be read through a separate index port.

Top module: `line_capture`

## Requirements
- R1: After reset the engine is idle: rx_ready is low, the status word (address 54h) reads 01h (only the transmit-empty bit set), and the count (address 55h) reads 0.
- R2: A start pulse sets the count, the sticky flags and the done flag to zero and raises rx_ready in the next cycle. Characters offered while rx_ready is low (before the first start or after a capture ends) are not stored and do not change the count.
- R3: An accepted character whose eight bits have even parity is stored at the next buffer index with bit 7 cleared. Reading address 52h then returns that 7-bit code, and status bit 1 (receive ready) is set. A read strobe on address 52h clears status bit 1.
- R4: An accepted character with odd parity is not stored. It sets the sticky parity-error flag (status bit 3) and closes rx_ready from the next cycle on, and the count keeps its value.
- R5: A stored carriage return (code 0Dh) is followed one cycle later by a line feed (0Ah) at the next index. rx_ready is low from the cycle after the carriage return. The count then includes both bytes, and status bit 2 (line done) is set.
- R6: If LINE_MAX+1 characters are stored without a carriage return, capture stops with the sticky overflow flag (status bit 4) set and no line feed, and the count equals LINE_MAX+1. A carriage return arriving as character LINE_MAX+1 ends the line normally, with a count of LINE_MAX+2.
- R7: Register map, read data combinational on bus_addr: 52h = last stored code, 53h = transmit holding byte, 54h = status {2'b0, busy, overflow, parity error, line done, receive ready, transmit empty} with bit 0 as the least significant bit, 55h = count. Every other address reads 00h. Status bit 5 (busy) is set while a capture or a line-feed append is in progress.
- R8: A write to 53h loads the transmit holding byte, raises tx_valid with that byte on tx_data, and clears status bit 0. tx_take clears tx_valid, and a write in the same cycle wins over tx_take.
- R9: buf_rdata returns the byte stored at index buf_raddr, with bit 7 reading as 0.
- R10: A start pulse in the middle of a capture discards the partial line, and the next character goes to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new capture |
| rx_valid | input | 1 | Receiver offers a character |
| rx_data | input | 8 | Received character, bit 7 is the even-parity bit |
| rx_ready | output | 1 | Engine accepts a character this cycle |
| bus_addr | input | 8 | Register port address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on 52h only) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| tx_valid | output | 1 | Transmit holding byte is full |
| tx_data | output | 8 | Transmit holding byte |
| tx_take | input | 1 | Downstream has taken the transmit byte |
| buf_raddr | input | PTR_W | Line buffer read index |
| buf_rdata | output | 8 | Line buffer byte at buf_raddr |

## Verification
The bench builds the engine with LINE_MAX set to 6, so the buffer has 8 entries. At that size both the overflow stop after 7 characters and the carriage return arriving as the 7th character, which fills the buffer exactly, take only a few dozen cycles. Parity errors, restarts during a capture and transmit-register traffic are interleaved with these lines. The read index is swept on every cycle, so each stored byte is compared while the capture is still running.

// File: rtl/lce_pkg.sv
// Shared constants and types for the line capture engine.
// Assumes byte-wide register addressing; status bit order is fixed by software.
package lce_pkg;
    localparam logic [7:0] ADDR_DIN  = 8'h52;
    localparam logic [7:0] ADDR_DOUT = 8'h53;
    localparam logic [7:0] ADDR_STAT = 8'h54;
    localparam logic [7:0] ADDR_CNT  = 8'h55;

    localparam logic [6:0] CODE_CR = 7'h0D;
    localparam logic [6:0] CODE_LF = 7'h0A;

    localparam int SB_TXE  = 0;
    localparam int SB_RXR  = 1;
    localparam int SB_DONE = 2;
    localparam int SB_PERR = 3;
    localparam int SB_OVF  = 4;
    localparam int SB_BUSY = 5;

    typedef enum logic [1:0] {CAP_IDLE, CAP_RUN, CAP_LF} cap_state_t;
endpackage

// File: rtl/lce_parity_strip.sv
// Splits a received byte into its 7-bit code and an even-parity verdict.
// Assumes bit 7 is the parity bit, chosen so the whole byte has even parity.
module lce_parity_strip (
    input  logic [7:0] raw,
    output logic [6:0] code,
    output logic       parity_ok
);
    // Purpose: drop the parity bit and test the byte for an even count of ones.
    always_comb begin
        code      = raw[6:0];
        parity_ok = ~(^raw);
    end
endmodule

// File: rtl/lce_line_buf.sv
// Line storage: one write port and one combinational read port, 7 bits per entry.
// Assumes the writer never addresses past DEPTH-1. Contents are not reset.
module lce_line_buf #(
    parameter int DEPTH = 82,
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [6:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [6:0]       rdata
);
    logic [6:0] mem [DEPTH];

    // Purpose: store one code per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: return the entry at raddr, or zero when raddr is outside the buffer.
    always_comb begin
        rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 7'h00;
    end
endmodule

// File: rtl/lce_capture_ctrl.sv
// Capture sequencer: accepts characters while running, stops on a parity error,
// a carriage return (then appends a line feed) or overflow past LINE_MAX+1 codes.
// Assumes start is a single-cycle pulse. The count doubles as the write pointer.
module lce_capture_ctrl
    import lce_pkg::*;
#(
    parameter int LINE_MAX = 80,
    parameter int DEPTH    = LINE_MAX + 2,
    parameter int PTR_W    = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rx_valid,
    input  logic [6:0]       code,
    input  logic             parity_ok,
    output logic             rx_ready,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [6:0]       wr_code,
    output logic             char_stored,
    output logic [CNT_W-1:0] count,
    output logic             line_done,
    output logic             par_err,
    output logic             ovf_err,
    output logic             busy
);
    cap_state_t state;
    logic       accept;

    // Purpose: derive the handshake, the buffer write and the per-character strobe.
    always_comb begin
        rx_ready    = (state == CAP_RUN);
        busy        = (state != CAP_IDLE);
        accept      = rx_valid && rx_ready && !start;
        char_stored = accept && parity_ok;
        wr_en       = char_stored || (state == CAP_LF && !start);
        wr_addr     = count[PTR_W-1:0];
        wr_code     = (state == CAP_LF) ? CODE_LF : code;
    end

    // Purpose: step the capture sequence and keep count and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CAP_IDLE;
            count     <= '0;
            line_done <= 1'b0;
            par_err   <= 1'b0;
            ovf_err   <= 1'b0;
        end else if (start) begin
            state     <= CAP_RUN;
            count     <= '0;
            line_done <= 1'b0;
            par_err   <= 1'b0;
            ovf_err   <= 1'b0;
        end else begin
            case (state)
                CAP_RUN: begin
                    if (accept && !parity_ok) begin
                        par_err <= 1'b1;
                        state   <= CAP_IDLE;
                    end else if (accept) begin
                        count <= count + CNT_W'(1);
                        if (code == CODE_CR) begin
                            state <= CAP_LF;
                        end else if (count == CNT_W'(LINE_MAX)) begin
                            ovf_err <= 1'b1;
                            state   <= CAP_IDLE;
                        end
                    end
                end
                CAP_LF: begin
                    count     <= count + CNT_W'(1);
                    line_done <= 1'b1;
                    state     <= CAP_IDLE;
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    assert_bad_parity_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !parity_ok && !start) |=> (par_err && !rx_ready));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0 && !par_err && !ovf_err && !line_done && rx_ready));

    assert_cr_closes_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stored && code == CODE_CR) |=> (!rx_ready && wr_en && wr_code == CODE_LF));

    assert_lf_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_LF && !start) |=> (line_done && !rx_ready));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    assert_one_abort_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_err && ovf_err) && !(line_done && (par_err || ovf_err)));
endmodule

// File: rtl/lce_reg_port.sv
// Byte-wide register port: last code (52h), transmit holding byte (53h),
// status (54h) and count (55h). Read data is combinational on the address.
// Assumes a read strobe on 52h acknowledges the receive-ready flag.
module lce_reg_port
    import lce_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_take,
    input  logic             char_stored,
    input  logic [6:0]       char_code,
    input  logic [CNT_W-1:0] count,
    input  logic             line_done,
    input  logic             par_err,
    input  logic             ovf_err,
    input  logic             busy
);
    logic [6:0] din_q;
    logic       rx_rdy;
    logic       tx_full;
    logic [7:0] tx_hold;
    logic [7:0] status;

    // Purpose: capture the last stored code and track its ready flag (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q  <= '0;
            rx_rdy <= 1'b0;
        end else if (char_stored) begin
            din_q  <= char_code;
            rx_rdy <= 1'b1;
        end else if (bus_rd && bus_addr == ADDR_DIN) begin
            rx_rdy <= 1'b0;
        end
    end

    // Purpose: hold the outgoing byte until downstream takes it (write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_hold <= '0;
        end else if (bus_wr && bus_addr == ADDR_DOUT) begin
            tx_full <= 1'b1;
            tx_hold <= bus_wdata;
        end else if (tx_take) begin
            tx_full <= 1'b0;
        end
    end

    // Purpose: assemble the status word and select read data by address.
    always_comb begin
        status          = '0;
        status[SB_TXE]  = ~tx_full;
        status[SB_RXR]  = rx_rdy;
        status[SB_DONE] = line_done;
        status[SB_PERR] = par_err;
        status[SB_OVF]  = ovf_err;
        status[SB_BUSY] = busy;
        case (bus_addr)
            ADDR_DIN:  bus_rdata = {1'b0, din_q};
            ADDR_DOUT: bus_rdata = tx_hold;
            ADDR_STAT: bus_rdata = status;
            ADDR_CNT:  bus_rdata = 8'(count);
            default:   bus_rdata = 8'h00;
        endcase
        tx_valid = tx_full;
        tx_data  = tx_hold;
    end

    assert_dout_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DOUT) |=> (tx_valid && tx_data == $past(bus_wdata)));

    assert_rx_flag_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_stored |=> (rx_rdy && din_q == $past(char_code)));
endmodule

// File: rtl/line_capture.sv
// Top of the parity-checked line capture engine. Wires the parity splitter,
// sequencer, line buffer and register port together.
// Assumes LINE_MAX stays small enough for the count to fit in eight bits.
module line_capture #(
    parameter  int LINE_MAX = 80,
    localparam int DEPTH    = LINE_MAX + 2,
    localparam int PTR_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_take,
    input  logic [PTR_W-1:0] buf_raddr,
    output logic [7:0]       buf_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [6:0]       code;
    logic             parity_ok;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [6:0]       wr_code;
    logic             char_stored;
    logic [CNT_W-1:0] count;
    logic             line_done, par_err, ovf_err, busy;
    logic [6:0]       rd_code;

    lce_parity_strip i_strip (.raw(rx_data), .code(code), .parity_ok(parity_ok));

    lce_capture_ctrl #(.LINE_MAX(LINE_MAX), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
        .code(code), .parity_ok(parity_ok), .rx_ready(rx_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
        .char_stored(char_stored), .count(count), .line_done(line_done),
        .par_err(par_err), .ovf_err(ovf_err), .busy(busy)
    );

    lce_line_buf #(.DEPTH(DEPTH), .PTR_W(PTR_W)) i_buf (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_code),
        .raddr(buf_raddr), .rdata(rd_code)
    );

    lce_reg_port #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .char_stored(char_stored), .char_code(code), .count(count),
        .line_done(line_done), .par_err(par_err), .ovf_err(ovf_err), .busy(busy)
    );

    // Purpose: present buffer entries as bytes with bit 7 clear.
    always_comb buf_rdata = {1'b0, rd_code};
endmodule

// File: tb/test_line_capture.sv
module test_line_capture;
    localparam int LM    = 6;
    localparam int DEPTH = LM + 2;
    localparam int PW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, start = 1'b0, rx_valid = 1'b0;
    logic [7:0]    rx_data = '0, bus_addr = 8'h54, bus_wdata = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0, tx_take = 1'b0;
    logic [PW-1:0] buf_raddr = '0;
    logic          rx_ready, tx_valid;
    logic [7:0]    bus_rdata, tx_data, buf_rdata;

    always #4 clk = ~clk;

    line_capture #(.LINE_MAX(LM)) i_line_capture (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_take(tx_take), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    // Reference model state
    bit         m_run, m_lf, m_perr, m_ovf, m_done, m_rxr, m_txf;
    logic [7:0] m_din, m_txd;
    logic [7:0] q[$];

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {2'b00, m_run | m_lf, m_ovf, m_perr, m_done, m_rxr, ~m_txf};
    endfunction

    function automatic logic [7:0] m_rdata(logic [7:0] a);
        case (a)
            8'h52:   return m_din;
            8'h53:   return m_txd;
            8'h54:   return m_status();
            8'h55:   return 8'(q.size());
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] par(logic [6:0] c);
        return {^c, c};
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_run = 0; m_lf = 0; m_perr = 0; m_ovf = 0; m_done = 0;
            m_rxr = 0; m_txf = 0; m_din = 0; m_txd = 0; q = {};
            return;
        end
        if (bus_rd && bus_addr == 8'h52) m_rxr = 0;
        if (bus_wr && bus_addr == 8'h53) begin m_txf = 1; m_txd = bus_wdata; end
        else if (tx_take) m_txf = 0;
        if (start) begin
            q = {}; m_run = 1; m_lf = 0; m_perr = 0; m_ovf = 0; m_done = 0;
        end else if (m_lf) begin
            q.push_back(8'h0A); m_done = 1; m_lf = 0;
        end else if (m_run && rx_valid) begin
            if ($countones(rx_data) % 2 == 1) begin
                m_perr = 1; m_run = 0;
            end else begin
                q.push_back({1'b0, rx_data[6:0]});
                m_din = {1'b0, rx_data[6:0]}; m_rxr = 1;
                if (rx_data[6:0] == 7'h0D) begin m_run = 0; m_lf = 1; end
                else if (q.size() == LM + 1) begin m_ovf = 1; m_run = 0; end
            end
        end
    endtask

    task automatic compare();
        chk("R2", "rx_ready", int'(rx_ready), int'(m_run));
        chk("R8", "tx_valid", int'(tx_valid), int'(m_txf));
        chk("R8", "tx_data", int'(tx_data), int'(m_txd));
        chk("R7", "bus_rdata", int'(bus_rdata), int'(m_rdata(bus_addr)));
        if (int'(buf_raddr) < q.size())
            chk("R9", "buf_rdata", int'(buf_rdata), int'(q[buf_raddr]));
    endtask

    // One clock: model follows the edge, outputs compared, defaults advanced.
    task automatic tick();
        @(posedge clk);
        #2;
        model_step();
        if (rst_n) compare();
        cyc++;
        buf_raddr = PW'(cyc % DEPTH);
        bus_addr  = (cyc % 2 == 0) ? 8'h54 : 8'h55;
    endtask

    task automatic peek(logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic send(logic [7:0] raw, int gap);
        rx_valid = 1'b1; rx_data = raw;
        tick();
        rx_valid = 1'b0;
        for (int i = 0; i < gap; i++) tick();
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        peek(8'h54, d); chk("R1", "status after reset", int'(d), 8'h01);
        peek(8'h55, d); chk("R1", "count after reset", int'(d), 0);
        chk("R1", "rx_ready after reset", int'(rx_ready), 0);

        // R2 characters before any start are ignored
        send(par(7'h5A), 1);
        peek(8'h55, d); chk("R2", "count before start", int'(d), 0);

        // R3 and R5: good line "AC" + CR
        pulse_start();
        chk("R2", "rx_ready after start", int'(rx_ready), 1);
        send(8'h41, 0);
        send(8'hC3, 1);
        buf_raddr = 1; #1 chk("R3", "stored code bit7 cleared", int'(buf_rdata), 8'h43);
        peek(8'h52, d); chk("R3", "data-in register", int'(d), 8'h43);
        peek(8'h54, d); chk("R3", "rx ready flag", int'(d[1]), 1);
        bus_rd = 1'b1; bus_addr = 8'h52; tick(); bus_rd = 1'b0;
        peek(8'h54, d); chk("R3", "rx ready cleared by read", int'(d[1]), 0);
        send(8'h8D, 0);
        chk("R5", "rx_ready low during LF append", int'(rx_ready), 0);
        tick();
        peek(8'h55, d); chk("R5", "count with CR and LF", int'(d), 4);
        buf_raddr = 2; #1 chk("R5", "CR stored", int'(buf_rdata), 8'h0D);
        buf_raddr = 3; #1 chk("R5", "LF appended", int'(buf_rdata), 8'h0A);
        peek(8'h54, d); chk("R5", "status after line", int'(d), 8'h07);
        send(par(7'h51), 1);
        peek(8'h55, d); chk("R2", "count after end, char ignored", int'(d), 4);

        // R4 parity error
        pulse_start();
        send(par(7'h78), 0);
        send(par(7'h79), 2);
        send(8'hC1, 1);
        peek(8'h55, d); chk("R4", "count after parity error", int'(d), 2);
        peek(8'h54, d); chk("R4", "status after parity error", int'(d), 8'h0B);
        chk("R4", "rx_ready after parity error", int'(rx_ready), 0);

        // R6 overflow with LM+1 characters
        pulse_start();
        for (int i = 0; i < LM + 1; i++) send(par(7'(8'h61 + i)), i % 2);
        tick();
        peek(8'h55, d); chk("R6", "count at overflow", int'(d), LM + 1);
        peek(8'h54, d); chk("R6", "status at overflow", int'(d), 8'h13);
        chk("R6", "rx_ready after overflow", int'(rx_ready), 0);

        // R6 boundary: CR as character LM+1 fills buffer exactly
        pulse_start();
        for (int i = 0; i < LM; i++) send(par(7'(8'h30 + i)), 0);
        send(8'h8D, 1);
        tick();
        peek(8'h55, d); chk("R6", "count with CR at limit", int'(d), LM + 2);
        peek(8'h54, d); chk("R6", "status with CR at limit", int'(d), 8'h07);
        buf_raddr = PW'(LM + 1); #1 chk("R6", "LF in last entry", int'(buf_rdata), 8'h0A);

        // R10 restart mid-capture
        pulse_start();
        send(par(7'h31), 0); send(par(7'h32), 0); send(par(7'h33), 0);
        pulse_start();
        send(par(7'h6B), 1);
        peek(8'h55, d); chk("R10", "count after restart", int'(d), 1);
        buf_raddr = 0; #1 chk("R10", "first entry after restart", int'(buf_rdata), 8'h6B);

        // R8 transmit holding register
        bus_wr = 1'b1; bus_addr = 8'h53; bus_wdata = 8'h5A; tick(); bus_wr = 1'b0;
        chk("R8", "tx_valid after write", int'(tx_valid), 1);
        chk("R8", "tx_data after write", int'(tx_data), 8'h5A);
        peek(8'h54, d); chk("R8", "tx empty bit clear", int'(d[0]), 0);
        bus_wr = 1'b1; bus_addr = 8'h53; bus_wdata = 8'hA5; tx_take = 1'b1; tick();
        bus_wr = 1'b0;
        chk("R8", "write wins over take", int'(tx_data), 8'hA5);
        tick(); tx_take = 1'b0;
        chk("R8", "tx_valid after take", int'(tx_valid), 0);

        // R7 map: data-out readback and unmapped address
        peek(8'h53, d); chk("R7", "data-out readback", int'(d), 8'hA5);
        peek(8'h60, d); chk("R7", "unmapped address", int'(d), 0);
        repeat (4) tick();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule